// File: doc/BRIEF.md
# Integer multiply-divide unit

This block is a 32-bit execution unit for integer multiplication, division and remainder. The pipeline presents two operands and a 3-bit operation code together with a one-cycle start strobe. The unit latches them, computes, and presents a 32-bit result with a one-cycle done pulse. While it works it raises busy. Any start strobe that arrives during that time is dropped.

Four codes select a part of the product. The low word of the product has one code. The high word has three codes: signed by signed, signed by unsigned and unsigned by unsigned. The multiply path sign-extends each operand to 33 bits according to the code, forms one signed 33x33 product and registers the chosen word once.

Four codes select division and remainder, each in signed and unsigned form. Division uses a 32-step restoring shift-subtract on magnitudes and fixes the signs afterwards. Two cases are detected before the loop and finish at once: a zero divisor, and the most negative dividend over minus one. Both give fixed results, so the unit never traps.

Top module: `muldiv_unit`

## Requirements
- R1: Code 000 returns bits 31:0 of the product of opA and opB.
- R2: Code 001 returns bits 63:32 of the product, with both operands taken as signed.
- R3: Code 010 returns bits 63:32 of the product, with opA taken as signed and opB as unsigned.
- R4: Code 011 returns bits 63:32 of the product, with both operands taken as unsigned.
- R5: Code 100 (signed quotient) truncates toward zero. Code 110 (signed remainder) gives a remainder that carries the sign of opA, so that quotient times opB plus remainder equals opA.
- R6: Code 101 returns the unsigned quotient and code 111 the unsigned remainder.
- R7: When opB is zero, codes 100 and 101 both return 0xFFFFFFFF.
- R8: When opB is zero, codes 110 and 111 both return opA unchanged.
- R9: When opA is 0x80000000 and opB is 0xFFFFFFFF, code 100 returns 0x80000000 and code 110 returns 0.
- R10: Let the clock edge that accepts start be edge 0. For a multiply, or for a division case covered by R7, R8 or R9, done and result are updated at edge 1. Any other division updates them at edge 32. Done is high for exactly one cycle.
- R11: Busy rises at the edge that accepts start and falls at the edge that raises done. Start is accepted only while busy is low. A start with other operands while busy is high changes neither the result nor the number of done pulses.
- R12: After reset, done, busy and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe; operands and code are sampled with it |
| opSel | input | 3 | Operation code (bit 2: divide; see R1 to R9) |
| opA | input | 32 | First operand, or dividend |
| opB | input | 32 | Second operand, or divisor |
| result | output | 32 | Result, updated together with done |
| done | output | 1 | One-cycle pulse marking a new result |
| busy | output | 1 | High while an operation is in progress |

## Verification
The multiply codes are run with operands of all four sign combinations, with the most negative value and with all ones. Only these patterns separate the signed, mixed and unsigned high words from each other and from the low word. Divisions cover all four sign pairings of dividend and divisor, plus exact and inexact quotients. These show whether the quotient truncates toward zero and whether the remainder follows the dividend's sign. The unsigned codes use operands above 2^31, which a signed path would get wrong. Zero divisors and the overflow pair check both the fixed values and the shortened latency. A start issued mid-division must leave the pending result intact, and back-to-back issues check that done is handed off cleanly between operations.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DIV  = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic latch;    // accept operands
    logic mulFin;   // register product word
    logic specFin;  // register fixed division result
    logic divStep;  // one shift-subtract iteration
    logic divFin;   // register sign-fixed division result
  } ctlStrobes_t;
endpackage

// File: rtl/muldiv_ctl.sv
module muldiv_ctl
  import muldiv_pkg::*;
#(
  parameter int ITERS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isDivOp,
  input  logic        isSpecial,
  output ctlStrobes_t strb,
  output logic        busy,
  output logic        done
);
  localparam int CW = $clog2(ITERS) + 1;
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  ctlState_t state;
  logic [CW-1:0] stepCnt;
  logic firstStep;

  assign firstStep = (stepCnt == '0);

  always_comb begin
    strb         = '0;
    strb.latch   = start && (state == ST_IDLE);
    strb.mulFin  = (state == ST_MUL);
    strb.specFin = (state == ST_DIV) && firstStep && isSpecial;
    strb.divStep = (state == ST_DIV) && !(firstStep && isSpecial);
    strb.divFin  = strb.divStep && (stepCnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          stepCnt <= '0;
          if (strb.latch) state <= isDivOp ? ST_DIV : ST_MUL;
        end
        ST_MUL: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        ST_DIV: begin
          if (strb.specFin || strb.divFin) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic [2:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             isSpecial,
  output logic [WIDTH-1:0] result
);
  localparam int PW = 2 * WIDTH + 2;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] aReg, bReg, divMag, remReg, quoReg;
  logic [2:0]       opReg;
  logic             negQ, negR;

  // operand magnitudes at accept time
  logic             sgnDivIn;
  logic [WIDTH-1:0] aMagIn, bMagIn;
  assign sgnDivIn = !opSel[0];
  assign aMagIn   = (sgnDivIn && opA[WIDTH-1]) ? (~opA + 1'b1) : opA;
  assign bMagIn   = (sgnDivIn && opB[WIDTH-1]) ? (~opB + 1'b1) : opB;

  // fixed division results
  logic bZero, sOvf;
  logic [WIDTH-1:0] specVal;
  assign bZero     = (bReg == '0);
  assign sOvf      = !opReg[0] && (aReg == MOST_NEG) && (bReg == '1);
  assign isSpecial = bZero || sOvf;
  always_comb begin
    if (bZero) specVal = opReg[1] ? aReg : '1;
    else       specVal = opReg[1] ? '0 : aReg;
  end

  // restoring iteration
  logic [WIDTH:0]   shifted, diff;
  logic             take;
  logic [WIDTH-1:0] remNext, quoNext, divOut;
  assign shifted = {remReg, quoReg[WIDTH-1]};
  assign diff    = shifted - {1'b0, divMag};
  assign take    = !diff[WIDTH];
  assign remNext = take ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
  assign quoNext = {quoReg[WIDTH-2:0], take};
  always_comb begin
    if (opReg[1]) divOut = negR ? (~remNext + 1'b1) : remNext;
    else          divOut = negQ ? (~quoNext + 1'b1) : quoNext;
  end

  // product with per-operand sign extension
  logic sgnA, sgnB;
  logic [WIDTH:0] extA, extB;
  logic signed [PW-1:0] prod;
  logic [WIDTH-1:0] mulOut;
  assign sgnA = (opReg[1:0] != 2'b11);
  assign sgnB = !opReg[1];
  assign extA = {sgnA & aReg[WIDTH-1], aReg};
  assign extB = {sgnB & bReg[WIDTH-1], bReg};
  assign prod = $signed(extA) * $signed(extB);
  assign mulOut = (opReg[1:0] == 2'b00) ? prod[WIDTH-1:0] : prod[2*WIDTH-1:WIDTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg   <= '0;
      bReg   <= '0;
      opReg  <= '0;
      divMag <= '0;
      remReg <= '0;
      quoReg <= '0;
      negQ   <= 1'b0;
      negR   <= 1'b0;
      result <= '0;
    end else begin
      if (strb.latch) begin
        aReg   <= opA;
        bReg   <= opB;
        opReg  <= opSel;
        divMag <= bMagIn;
        quoReg <= aMagIn;
        remReg <= '0;
        negQ   <= sgnDivIn && (opA[WIDTH-1] ^ opB[WIDTH-1]);
        negR   <= sgnDivIn && opA[WIDTH-1];
      end
      if (strb.divStep) begin
        remReg <= remNext;
        quoReg <= quoNext;
      end
      if (strb.mulFin)  result <= mulOut;
      if (strb.specFin) result <= specVal;
      if (strb.divFin)  result <= divOut;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             done,
  output logic             busy
);
  ctlStrobes_t strb;
  logic isSpecial;

  muldiv_ctl #(.ITERS(WIDTH)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .isDivOp(opSel[2]),
    .isSpecial(isSpecial), .strb(strb), .busy(busy), .done(done)
  );

  muldiv_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opSel(opSel), .opA(opA),
    .opB(opB), .isSpecial(isSpecial), .result(result)
  );
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [2:0]       opSel,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] result,
  input logic             done,
  input logic             busy
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam int CW = $clog2(WIDTH) + 2;

  logic accept;
  assign accept = start && !busy;

  logic [CW-1:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  a_r10_mul_latency: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !opSel[2]) |=> ##1 done);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_div_window: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= CW'(WIDTH));
  a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r7_div_zero: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opSel[2:1] == 2'b10 && opB == '0) |=> ##1 (done && result == '1));
  a_r8_rem_zero: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opSel[2:1] == 2'b11 && opB == '0) |=> ##1 (done && result == $past(opA, 2)));
  a_r9_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opSel == 3'b100 && opA == MOST_NEG && opB == '1) |=> ##1 (done && result == MOST_NEG));
endmodule

bind muldiv_unit muldiv_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .opA(opA),
  .opB(opB), .result(result), .done(done), .busy(busy)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] opSel = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [31:0] result;
  logic done, busy;

  always #4 clk = ~clk;

  muldiv_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .opA(opA),
    .opB(opB), .result(result), .done(done), .busy(busy)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nTests = 0, nFail = 0, pending = 0;
  logic [31:0] expQ[$];
  int latQ[$];
  int issQ[$];
  string tagQ[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    longint sa, sb, ub;
    logic [63:0] uu;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ub = longint'({32'b0, b});
    uu = {32'b0, a} * {32'b0, b};
    case (op)
      3'b000: model = 32'(sa * sb);
      3'b001: model = 32'((sa * sb) >>> 32);
      3'b010: model = 32'((sa * ub) >>> 32);
      3'b011: model = uu[63:32];
      3'b100: model = (b == 0) ? 32'hFFFFFFFF :
                      (a == 32'h80000000 && b == 32'hFFFFFFFF) ? 32'h80000000 : 32'(sa / sb);
      3'b101: model = (b == 0) ? 32'hFFFFFFFF : a / b;
      3'b110: model = (b == 0) ? a :
                      (a == 32'h80000000 && b == 32'hFFFFFFFF) ? 32'h0 : 32'(sa % sb);
      default: model = (b == 0) ? a : a % b;
    endcase
  endfunction

  // cycles from the driving negedge to the sampling negedge (R10)
  function automatic int latency(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    if (!op[2]) return 2;
    if (b == 0) return 2;
    if (!op[0] && a == 32'h80000000 && b == 32'hFFFFFFFF) return 2;
    return 33;
  endfunction

  task automatic issue(logic [2:0] op, logic [31:0] a, logic [31:0] b, string tag);
    while (pending != 0) @(negedge clk);
    opSel = op; opA = a; opB = b; start = 1'b1;
    expQ.push_back(model(op, a, b));
    latQ.push_back(latency(op, a, b));
    issQ.push_back(cyc);
    tagQ.push_back(tag);
    pending++;
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        nTests++; nFail++;
        $display("FAIL R11: unexpected done, actual result %h expected no done", result);
      end else begin
        string t;
        int lat, iss;
        t = tagQ.pop_front();
        lat = latQ.pop_front();
        iss = issQ.pop_front();
        check(t, result, expQ.pop_front());
        check({t, "/R10 latency"}, 32'(cyc - iss), 32'(lat));
        pending--;
      end
    end
  end

  initial begin
    #1000000;
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 done", {31'b0, done}, 32'h0);
    check("R12 busy", {31'b0, busy}, 32'h0);
    check("R12 result", result, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    issue(3'b000, 32'd7, 32'd6, "R1 small");
    issue(3'b000, 32'hFFFFFFFD, 32'h12345678, "R1 neg");
    issue(3'b000, 32'hDEADBEEF, 32'hCAFEF00D, "R1 wide");
    issue(3'b001, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2 neg*neg");
    issue(3'b001, 32'h80000000, 32'h7FFFFFFF, "R2 min*max");
    issue(3'b001, 32'h80000000, 32'h80000000, "R2 min*min");
    issue(3'b010, 32'hFFFFFFFF, 32'hFFFFFFFF, "R3 neg*big");
    issue(3'b010, 32'h12345678, 32'h9ABCDEF0, "R3 pos*big");
    issue(3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, "R4 max*max");
    issue(3'b011, 32'h80000000, 32'h00000003, "R4 msb");
    issue(3'b100, 32'd7, 32'd2, "R5 pos/pos");
    issue(3'b100, 32'hFFFFFFF9, 32'd2, "R5 neg/pos");
    issue(3'b100, 32'd7, 32'hFFFFFFFE, "R5 pos/neg");
    issue(3'b100, 32'hFFFFFFF9, 32'hFFFFFFFE, "R5 neg/neg");
    issue(3'b110, 32'hFFFFFFF9, 32'd2, "R5 rem neg/pos");
    issue(3'b110, 32'd7, 32'hFFFFFFFE, "R5 rem pos/neg");
    issue(3'b110, 32'h80000000, 32'd3, "R5 rem min/3");
    issue(3'b100, 32'd100, 32'd10, "R5 exact");
    issue(3'b101, 32'hFFFFFFFF, 32'd3, "R6 divu big");
    issue(3'b101, 32'h80000000, 32'hFFFFFFFF, "R6 divu no ovf");
    issue(3'b111, 32'hFFFFFFF9, 32'd10, "R6 remu big");
    issue(3'b111, 32'd5, 32'hFFFFFFF0, "R6 remu small");
    issue(3'b100, 32'd1234, 32'd0, "R7 div zero");
    issue(3'b101, 32'h80000000, 32'd0, "R7 divu zero");
    issue(3'b110, 32'hFFFFFF85, 32'd0, "R8 rem zero");
    issue(3'b111, 32'hA5A5A5A5, 32'd0, "R8 remu zero");
    issue(3'b100, 32'h80000000, 32'hFFFFFFFF, "R9 div ovf");
    issue(3'b110, 32'h80000000, 32'hFFFFFFFF, "R9 rem ovf");

    // R11: start while busy is dropped
    issue(3'b101, 32'd1000, 32'd7, "R11 pending divu");
    repeat (3) @(negedge clk);
    check("R11 busy mid-divide", {31'b0, busy}, 32'h1);
    opSel = 3'b000; opA = 32'd3; opB = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (pending != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R11 idle after", {31'b0, busy}, 32'h0);
    check("R11 result kept", result, 32'd142);

    issue(3'b000, 32'd9, 32'd9, "R11 after drop");
    while (pending != 0) @(negedge clk);
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule